// File: doc/BRIEF.md
# PCIe Lane Margining Relay Registers

This block is a per-lane register file that relays receiver lane-margining commands from a PCIe controller to software, which in turn drives a PHY-side margining agent. It watches the controller's margin command stream through a snoop port. While software has armed it, it latches each command word into a local read-only control register and classifies the command as start, change or stop. Each class sets its own interrupt cause bit. A rising edge of the link's 16 GT/s indication sets a readiness cause. Causes are masked by an enable register and combined onto one level interrupt.

Software uses the block as follows. It answers readiness by setting its two ready flags. It reads the latched control word after each start or change interrupt and hands it to the PHY agent. It then writes the returned error count into the margin status register, which drives the controller-facing status output. Two further software flags, PHY margin status and PHY margin error, are driven straight to the controller side.

Top module: `margin_relay_top`

## Requirements
- R1: After reset every register reads zero, the interrupt is low, and the status and flag outputs are zero.
- R2: The readiness cause (bit 0) is set on the clock edge where the 16 GT/s indication is first seen high after being low. Holding the indication high does not set it again.
- R3: Snooped commands are ignored unless status bits 0 (software ready) and 1 (margin ready) are both 1. An ignored command changes neither the control register nor the causes.
- R4: An accepted command copies the whole 23-bit snooped word into the control register (offset 3), with the fields laid out as follows: enable at bit 0, clear at bit 1, X offset at bits 8:2, Y offset at bits 14:9, block count at bits 22:15. The cause bit appears in the same cycle as the new word, never earlier.
- R5: Command code 1 sets cause bit 1 (start), code 2 sets bit 2 (change), code 3 sets bit 3 (stop), and code 0 is ignored. The stop code also latches its word.
- R6: The cause register (offset 1) is write-one-to-clear on bits 3:0. A cause set by hardware in the same cycle as a clear of that bit stays set.
- R7: The interrupt is high exactly when some cause bit and the matching bit of the enable register (offset 0) are both 1.
- R8: The margin status register (offset 4) keeps only the low 16 bits of a write, reads back with upper bits zero, and drives the 16-bit error count output.
- R9: The software status register (offset 2) keeps bits 3:0 only. Bit 2 drives phy flag output bit 0, and bit 3 drives phy flag output bit 1.
- R10: A command accepted while an earlier cause is still pending overwrites the control register and adds its own cause bit, leaving the earlier cause set.
- R11: The control register ignores bus writes, and offsets 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register word offset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| snpValid | input | 1 | Snooped command valid this cycle |
| snpCmd | input | 2 | Command code: 0 none, 1 start, 2 change, 3 stop |
| snpWord | input | 23 | Snooped margin control word |
| linkFast | input | 1 | Link is running at 16 GT/s |
| errCntOut | output | 16 | Margin error count toward the controller |
| phyFlagsOut | output | 2 | PHY margin status (bit 0) and error (bit 1) toward the controller |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the snoop valid is a one-cycle strobe and that the command code is only meaningful while it is high. They also assume software is the only writer of the cause and status registers. The readiness assertion assumes the link indication is a registered level, not a glitch. The stimulus drives every input on the falling edge and holds it for a full cycle. It pulses the snoop and bus strobes for exactly one cycle, and keeps the link indication low through reset. This keeps each capture, cause set and clear aligned to a single known rising edge.

// File: rtl/margin_relay_pkg.sv
package margin_relay_pkg;
  localparam int ADDR_W   = 3;
  localparam int CAUSE_W  = 4;
  localparam int NUM_REGS = 5;

  localparam logic [ADDR_W-1:0] ADDR_INTEN  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SWSTAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MSTAT  = 3'd4;

  localparam int IDX_READY  = 0;
  localparam int IDX_START  = 1;
  localparam int IDX_CHANGE = 2;
  localparam int IDX_STOP   = 3;

  localparam int SW_READY  = 0;
  localparam int MRG_READY = 1;
  localparam int PHY_STAT  = 2;
  localparam int PHY_ERR   = 3;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_START  = 2'd1,
    CMD_CHANGE = 2'd2,
    CMD_STOP   = 2'd3
  } snpCmdE;

  typedef struct packed {
    logic               capture;
    logic [CAUSE_W-1:0] setCause;
  } relayStrbT;
endpackage

// File: rtl/margin_relay_ctrl.sv
module margin_relay_ctrl
  import margin_relay_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linkFast,
  input  logic      snpValid,
  input  logic [1:0] snpCmd,
  input  logic      readyBoth,
  output relayStrbT strb
);
  logic linkPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) linkPrevQ <= 1'b0;
    else       linkPrevQ <= linkFast;
  end

  always_comb begin
    strb = '0;
    strb.setCause[IDX_READY] = linkFast & ~linkPrevQ;
    if (snpValid && readyBoth && (snpCmd != CMD_NONE)) begin
      strb.capture = 1'b1;
      case (snpCmd)
        CMD_START:  strb.setCause[IDX_START]  = 1'b1;
        CMD_CHANGE: strb.setCause[IDX_CHANGE] = 1'b1;
        CMD_STOP:   strb.setCause[IDX_STOP]   = 1'b1;
        default:    ;
      endcase
    end
  end

  // R5: at most one command class per accepted command
  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.setCause[CAUSE_W-1:1]));

  // R2: readiness is only raised while the link indication is high
  assert_ready_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setCause[IDX_READY] |-> linkFast);
endmodule

// File: rtl/margin_relay_regs.sv
module margin_relay_regs
  import margin_relay_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 23,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CTRL_W-1:0] snpWord,
  input  relayStrbT         strb,
  output logic              readyBoth,
  output logic              irq,
  output logic [ERR_W-1:0]  errCntOut,
  output logic [1:0]        phyFlagsOut
);
  localparam int SW_W = 4;

  logic [CAUSE_W-1:0]  intEnQ, causeQ, causeD, clrMask;
  logic [SW_W-1:0]     swStatQ;
  logic [CTRL_W-1:0]   ctrlQ;
  logic [ERR_W-1:0]    errCntQ;
  logic [NUM_REGS-1:0] wrSel;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      wrSel[i] = busWrEn && (busAddr == ADDR_W'(i));
  end

  assign clrMask = wrSel[ADDR_CAUSE] ? busWrData[CAUSE_W-1:0] : '0;
  assign causeD  = (causeQ & ~clrMask) | strb.setCause;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnQ  <= '0;
      causeQ  <= '0;
      swStatQ <= '0;
      ctrlQ   <= '0;
      errCntQ <= '0;
    end else begin
      causeQ <= causeD;
      if (wrSel[ADDR_INTEN])  intEnQ  <= busWrData[CAUSE_W-1:0];
      if (wrSel[ADDR_SWSTAT]) swStatQ <= busWrData[SW_W-1:0];
      if (wrSel[ADDR_MSTAT])  errCntQ <= busWrData[ERR_W-1:0];
      if (strb.capture)       ctrlQ   <= snpWord;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_INTEN:  busRdData[CAUSE_W-1:0] = intEnQ;
      ADDR_CAUSE:  busRdData[CAUSE_W-1:0] = causeQ;
      ADDR_SWSTAT: busRdData[SW_W-1:0]    = swStatQ;
      ADDR_CTRL:   busRdData[CTRL_W-1:0]  = ctrlQ;
      ADDR_MSTAT:  busRdData[ERR_W-1:0]   = errCntQ;
      default:     ;
    endcase
  end

  assign readyBoth   = swStatQ[SW_READY] & swStatQ[MRG_READY];
  assign irq         = |(causeQ & intEnQ);
  assign errCntOut   = errCntQ;
  assign phyFlagsOut = {swStatQ[PHY_ERR], swStatQ[PHY_STAT]};

  // R3: without both ready flags the control word cannot move
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !readyBoth |=> $stable(ctrlQ));

  // R4: an accepted command lands in the control register one edge later
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (ctrlQ == $past(snpWord)));

  // R6: pending causes only drop through a cause-register write
  assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrSel[ADDR_CAUSE] |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  // R8: the error count output follows the low half of a status write
  assert_errcnt_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrSel[ADDR_MSTAT] |=> (errCntOut == $past(busWrData[ERR_W-1:0])));
endmodule

// File: rtl/margin_relay_top.sv
module margin_relay_top
  import margin_relay_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 23,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [CTRL_W-1:0] snpWord,
  input  logic              linkFast,
  output logic [ERR_W-1:0]  errCntOut,
  output logic [1:0]        phyFlagsOut,
  output logic              irq
);
  relayStrbT strb;
  logic      readyBoth;

  margin_relay_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .linkFast  (linkFast),
    .snpValid  (snpValid),
    .snpCmd    (snpCmd),
    .readyBoth (readyBoth),
    .strb      (strb)
  );

  margin_relay_regs #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .ERR_W  (ERR_W)
  ) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .snpWord     (snpWord),
    .strb        (strb),
    .readyBoth   (readyBoth),
    .irq         (irq),
    .errCntOut   (errCntOut),
    .phyFlagsOut (phyFlagsOut)
  );
endmodule

// File: tb/tb_margin_relay_top.sv
module tb_margin_relay_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 23;
  localparam int ERR_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              snpValid = 1'b0;
  logic [1:0]        snpCmd = '0;
  logic [CTRL_W-1:0] snpWord = '0;
  logic              linkFast = 1'b0;
  logic [ERR_W-1:0]  errCntOut;
  logic [1:0]        phyFlagsOut;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  margin_relay_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .snpValid(snpValid),
    .snpCmd(snpCmd), .snpWord(snpWord), .linkFast(linkFast),
    .errCntOut(errCntOut), .phyFlagsOut(phyFlagsOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [CTRL_W-1:0] w);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = c; snpWord = w;
    @(negedge clk);
    snpValid = 1'b0; snpCmd = 2'd0;
  endtask

  task automatic pulseLink();
    @(negedge clk);
    linkFast = 1'b1;
    @(negedge clk);
    linkFast = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [CTRL_W-1:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), rd);
      check("R1 reset readback", rd, 32'h0);
    end
    #1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 errCnt", {16'b0, errCntOut}, 32'h0);
    check("R1 flags", {30'b0, phyFlagsOut}, 32'h0);

    // R3 gating by the two ready flags
    for (int s = 0; s < 3; s++) begin
      busWrite(3'd2, 32'(s));
      snoop(2'd1, 23'h12345);
      busRead(3'd3, rd);
      check("R3 ctrl untouched", rd, 32'h0);
      busRead(3'd1, rd);
      check("R3 cause untouched", rd, 32'h0);
    end

    busWrite(3'd2, 32'h3);
    // R4 walking-one capture over all 23 bits
    for (int i = 0; i < CTRL_W; i++) begin
      w = CTRL_W'(1) << i;
      snoop(2'd2, w);
      busRead(3'd3, rd);
      check("R4 ctrl capture", rd, 32'(w));
    end
    // R4 field layout: en=1 clr=0 X=0x55 Y=0x2A blocks=0xC3
    w = CTRL_W'((32'hC3 << 15) | (32'h2A << 9) | (32'h55 << 2) | 32'h1);
    snoop(2'd1, w);
    busRead(3'd3, rd);
    check("R4 field blocks", (rd >> 15) & 32'hFF, 32'hC3);
    check("R4 field Y", (rd >> 9) & 32'h3F, 32'h2A);
    check("R4 field X", (rd >> 2) & 32'h7F, 32'h55);
    check("R4 field en/clr", rd & 32'h3, 32'h1);

    // R5 classification
    for (int c = 0; c < 4; c++) begin
      busWrite(3'd1, 32'hF);
      w = CTRL_W'(32'h100 + c);
      snoop(2'(c), w);
      busRead(3'd1, rd);
      check("R5 cause class", rd, (c == 0) ? 32'h0 : (32'h1 << c));
      busRead(3'd3, rd);
      check("R5 ctrl on class", rd, (c == 0) ? 32'(CTRL_W'((32'hC3 << 15) | (32'h2A << 9) | (32'h55 << 2) | 32'h1)) : (32'h100 + c));
    end

    // R7 interrupt sweep: each cause against all 16 enable masks
    for (int b = 0; b < 4; b++) begin
      busWrite(3'd1, 32'hF);
      if (b == 0) pulseLink();
      else snoop(2'(b), 23'h7);
      for (int en = 0; en < 16; en++) begin
        busWrite(3'd0, 32'(en));
        #1;
        check("R7 irq vs enable", {31'b0, irq}, 32'((en >> b) & 1));
      end
    end
    busWrite(3'd0, 32'h0);
    busWrite(3'd1, 32'hF);

    // R2 readiness on rising edge only
    @(negedge clk); linkFast = 1'b1;
    @(negedge clk);
    busRead(3'd1, rd);
    check("R2 readiness set", rd, 32'h1);
    busWrite(3'd1, 32'h1);
    repeat (4) @(negedge clk);
    busRead(3'd1, rd);
    check("R2 held level no re-raise", rd, 32'h0);
    @(negedge clk); linkFast = 1'b0;
    pulseLink();
    busRead(3'd1, rd);
    check("R2 second edge", rd, 32'h1);

    // R6 write-one-to-clear
    busWrite(3'd1, 32'hF);
    snoop(2'd1, 23'h1); snoop(2'd2, 23'h2); snoop(2'd3, 23'h3);
    busRead(3'd1, rd);
    check("R6 three causes", rd, 32'hE);
    busWrite(3'd1, 32'h4);
    busRead(3'd1, rd);
    check("R6 partial clear", rd, 32'hA);
    busWrite(3'd1, 32'hF);
    @(negedge clk);
    busAddr = 3'd1; busWrData = 32'h2; busWrEn = 1'b1;
    snpValid = 1'b1; snpCmd = 2'd1; snpWord = 23'h44;
    @(negedge clk);
    busWrEn = 1'b0; snpValid = 1'b0; snpCmd = 2'd0;
    busRead(3'd1, rd);
    check("R6 set beats clear", rd, 32'h2);

    // R10 overwrite while pending
    busWrite(3'd1, 32'hF);
    snoop(2'd1, 23'h1AAAA);
    snoop(2'd2, 23'h05555);
    busRead(3'd3, rd);
    check("R10 newer word kept", rd, 32'h05555);
    busRead(3'd1, rd);
    check("R10 both causes", rd, 32'h6);

    // R8 margin status width
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = 32'hDEAD0000 ^ (32'h1357_9BDF * (k + 1));
      busWrite(3'd4, v);
      busRead(3'd4, rd);
      check("R8 readback low half", rd, v & 32'hFFFF);
      check("R8 errCntOut", {16'b0, errCntOut}, v & 32'hFFFF);
    end

    // R9 software status width and flag outputs
    for (int s = 0; s < 16; s++) begin
      busWrite(3'd2, 32'hFFFF_FFF0 | 32'(s));
      busRead(3'd2, rd);
      check("R9 swstat readback", rd, 32'(s));
      check("R9 phy flags", {30'b0, phyFlagsOut}, 32'((s >> 2) & 3));
    end

    // R11 read-only control and unmapped offsets
    busRead(3'd3, rd);
    busWrite(3'd3, 32'h7FFFFF);
    begin
      logic [31:0] rd2;
      busRead(3'd3, rd2);
      check("R11 ctrl write ignored", rd2, rd);
    end
    for (int a = 5; a < 8; a++) begin
      busRead(3'(a), rd);
      check("R11 unmapped zero", rd, 32'h0);
    end

    finishRun();
  end
endmodule